// File: doc/BRIEF.md
# Root Hub Port Status Controller

This block holds the status word of one downstream port of a USB host root hub and runs the timers behind it. Software sees a single 32-bit register. The lower half shows the live port state: suspended, over-current, resume in progress and reset in progress. The upper half holds sticky change flags that the block sets when hardware events finish.

Software starts a port reset, a suspend or a resume by writing command bits into the lower half. The block times the reset interval and the three-phase resume sequence from a millisecond tick input. Each phase of the resume is timed separately: a resume drive, then a low-speed end-of-packet, then a resynchronisation delay. When a reset or a resume finishes, the block sets the matching change flag. The block also samples an over-current input and flags every change in it.

Change flags are cleared by writing one to them. A clear that arrives while a token-to-handshake transaction is running is not lost. It is parked and applied once the bus goes quiet. The register bus is plain and single-cycle: a write takes effect on the clock edge where the write enable is high, and the read data always shows the current register value. There is no handshake at the edge of the block.

Top module: `rhp_port_status`

## Requirements
- R1: After reset the register reads 0x00000000. Bits 31:21, bit 3 and bits 17:5 always read 0. Writing ones to these bits has no effect.
- R2: The status bits are laid out as follows. Bit 0 is 1 while the port is suspended, up to the end of the resume sequence. Bit 1 is the sampled over-current input. Bit 2 is 1 while a resume sequence runs. Bit 4 is 1 while a port reset runs. Writing 1 to bit 0 from the active state suspends the port. Writing 1 to bit 2 while suspended starts a resume. Writing 1 to bit 4 starts a port reset.
- R3: A port reset keeps bit 4 at 1 for RST_MS (default 10) ms ticks. On the edge that takes the last tick, bit 4 falls to 0 and bit 20 is set.
- R4: Bit 19 is set on the same edge on which bit 1 changes value, in either direction.
- R5: Bit 18 is set only after the whole resume sequence has run. The sequence is RES_MS (20) ticks of drive, then EOP_CLKS (4) clock cycles of end-of-packet, then SYNC_MS (3) ticks of resync. Bits 0 and 2 fall on the same edge that sets bit 18.
- R6: Whenever bit 20 becomes set, bit 18 is cleared.
- R7: Writing 1 to bit 20, 19 or 18 clears that flag. Writing 0 to a flag leaves it unchanged.
- R8: A flag-clearing write made while txn_busy is 1 is held. It is applied on the first clock edge at which txn_busy is 0.
- R9: Further flag-clearing writes made while a clear is held are OR-merged into the held mask.
- R10: If hardware sets a flag on the same edge that software clears it, the flag ends up set.
- R11: Writing 1 to bit 4 during a resume sequence aborts the resume. Bit 18 is then not set for that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Current register value |
| txn_busy | input | 1 | High while a token-to-handshake transaction is in flight |
| oc_in | input | 1 | Over-current indicator input |
| ms_tick | input | 1 | One-cycle pulse per millisecond |

## Verification
The hardest situations to reach from the ports are the collisions. One is a held clear that must merge with a second write before the bus goes idle. Another is a hardware set that lands on the very edge of a software clear. The third is a reset that cuts into a resume partway through its drive phase.

The stimulus table drives txn_busy and oc_in by hand, cycle by cycle, to line up each of these edges. Directed sequences then count ticks exactly to the last cycle of each timed phase. They start a reset in the middle of a resume and keep ticking afterwards, to show that the suspend change flag never appears.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  typedef enum logic [2:0] {
    SQ_ACTIVE,
    SQ_SUSP,
    SQ_RDRV,
    SQ_REOP,
    SQ_RSYNC,
    SQ_RESET
  } seq_st_e;

  localparam int unsigned B_SUSP   = 0;
  localparam int unsigned B_OC     = 1;
  localparam int unsigned B_RESUME = 2;
  localparam int unsigned B_RESET  = 4;
  localparam int unsigned CHG_LO   = 18;
  localparam int unsigned NCHG     = 3;
  // index inside the change-flag vector
  localparam int unsigned C_SUSP   = 0;
  localparam int unsigned C_OC     = 1;
  localparam int unsigned C_RESET  = 2;
endpackage

// File: rtl/rhp_oc_sync.sv
module rhp_oc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_in,
  output logic oc_stat,
  output logic oc_chg
);
  logic oc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_in;
  end

  assign oc_stat = oc_q;
  assign oc_chg  = oc_in ^ oc_q;
endmodule

// File: rtl/rhp_seq.sv
module rhp_seq import rhp_pkg::*; #(
  parameter int unsigned RST_MS   = 10,
  parameter int unsigned RES_MS   = 20,
  parameter int unsigned SYNC_MS  = 3,
  parameter int unsigned EOP_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic req_reset,
  input  logic req_susp,
  input  logic req_resume,
  output logic st_susp,
  output logic st_resume,
  output logic st_reset,
  output logic reset_done,
  output logic resume_done
);
  localparam int unsigned M1   = (RST_MS > RES_MS) ? RST_MS : RES_MS;
  localparam int unsigned M2   = (M1 > SYNC_MS) ? M1 : SYNC_MS;
  localparam int unsigned MAXN = (M2 > EOP_CLKS) ? M2 : EOP_CLKS;
  localparam int unsigned CW   = $clog2(MAXN + 1);

  seq_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic step, last;

  // each timed phase picks its length and its step source
  always_comb begin
    lim  = '0;
    step = 1'b0;
    case (st_q)
      SQ_RDRV:  begin lim = CW'(RES_MS - 1);   step = ms_tick; end
      SQ_REOP:  begin lim = CW'(EOP_CLKS - 1); step = 1'b1;    end
      SQ_RSYNC: begin lim = CW'(SYNC_MS - 1);  step = ms_tick; end
      SQ_RESET: begin lim = CW'(RST_MS - 1);   step = ms_tick; end
      default:  ;
    endcase
  end

  assign last = step && (cnt_q == lim);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (step) cnt_d = last ? '0 : cnt_q + 1'b1;
    case (st_q)
      SQ_ACTIVE: if (req_susp) st_d = SQ_SUSP;
      SQ_SUSP:   if (req_resume) begin st_d = SQ_RDRV; cnt_d = '0; end
      SQ_RDRV:   if (last) st_d = SQ_REOP;
      SQ_REOP:   if (last) st_d = SQ_RSYNC;
      SQ_RSYNC:  if (last) st_d = SQ_ACTIVE;
      SQ_RESET:  if (last) st_d = SQ_ACTIVE;
      default:   st_d = SQ_ACTIVE;
    endcase
    // reset request overrides everything, aborting a resume (R11)
    if (req_reset && st_q != SQ_RESET) begin
      st_d  = SQ_RESET;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_ACTIVE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_resume   = (st_q == SQ_RDRV) || (st_q == SQ_REOP) || (st_q == SQ_RSYNC);
  assign st_susp     = (st_q == SQ_SUSP) || st_resume;
  assign st_reset    = (st_q == SQ_RESET);
  assign reset_done  = (st_q == SQ_RESET) && last;
  assign resume_done = (st_q == SQ_RSYNC) && last && !req_reset;

  p_reset_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RESET && !ms_tick) |=> (st_q == SQ_RESET));

  p_resume_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RSYNC) |-> ($past(st_q) == SQ_REOP || $past(st_q) == SQ_RSYNC));

  p_eop_from_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_REOP) |-> ($past(st_q) == SQ_RDRV || $past(st_q) == SQ_REOP));

  p_abort_resume_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_reset && st_resume) |=> (st_q == SQ_RESET));
endmodule

// File: rtl/rhp_chg_flags.sv
module rhp_chg_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] wipe_i,
  input  logic         wr_i,
  input  logic [N-1:0] wmask_i,
  input  logic         busy_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d, pend_q, pend_d, req, clr;

  assign req    = wr_i ? wmask_i : '0;
  assign clr    = busy_i ? '0 : (pend_q | req);
  assign pend_d = busy_i ? (pend_q | req) : '0;

  // sets beat both software clears and wipes
  always_comb begin
    for (int k = 0; k < int'(N); k++)
      flags_d[k] = set_i[k] | (flags_q[k] & ~clr[k] & ~wipe_i[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      pend_q  <= '0;
    end else begin
      flags_q <= flags_d;
      pend_q  <= pend_d;
    end
  end

  assign flags_o = flags_q;

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && wipe_i == '0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  p_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_i != '0) |=> ((flags_o & $past(wipe_i & ~set_i)) == '0));

  p_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && $past(busy_i) && set_i == '0) |=> ((flags_o & $past(pend_q)) == '0));
endmodule

// File: rtl/rhp_port_status.sv
module rhp_port_status import rhp_pkg::*; #(
  parameter int unsigned RST_MS   = 10,
  parameter int unsigned RES_MS   = 20,
  parameter int unsigned SYNC_MS  = 3,
  parameter int unsigned EOP_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        txn_busy,
  input  logic        oc_in,
  input  logic        ms_tick
);
  logic oc_stat, oc_chg;
  logic st_susp, st_resume, st_reset, reset_done, resume_done;
  logic [NCHG-1:0] set_v, wipe_v, chg;

  rhp_oc_sync u_oc (
    .clk(clk), .rst_n(rst_n), .oc_in(oc_in),
    .oc_stat(oc_stat), .oc_chg(oc_chg)
  );

  rhp_seq #(
    .RST_MS(RST_MS), .RES_MS(RES_MS), .SYNC_MS(SYNC_MS), .EOP_CLKS(EOP_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .req_reset(wr_en & wdata[B_RESET]),
    .req_susp(wr_en & wdata[B_SUSP]),
    .req_resume(wr_en & wdata[B_RESUME]),
    .st_susp(st_susp), .st_resume(st_resume), .st_reset(st_reset),
    .reset_done(reset_done), .resume_done(resume_done)
  );

  always_comb begin
    set_v           = '0;
    set_v[C_RESET]  = reset_done;
    set_v[C_OC]     = oc_chg;
    set_v[C_SUSP]   = resume_done;
    wipe_v          = '0;
    wipe_v[C_SUSP]  = reset_done;   // R6
  end

  rhp_chg_flags #(.N(NCHG)) u_chg (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .wipe_i(wipe_v),
    .wr_i(wr_en), .wmask_i(wdata[CHG_LO +: NCHG]), .busy_i(txn_busy),
    .flags_o(chg)
  );

  always_comb begin
    rdata                   = '0;
    rdata[B_SUSP]           = st_susp;
    rdata[B_OC]             = oc_stat;
    rdata[B_RESUME]         = st_resume;
    rdata[B_RESET]          = st_reset;
    rdata[CHG_LO +: NCHG]   = chg;
  end

  p_oc_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_stat != $past(oc_stat)) |-> chg[C_OC]);

  p_reset_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_reset) && !$past(wr_en && wdata[B_RESET])) |-> chg[C_RESET]);
endmodule

// File: tb/rhp_port_status_bench.sv
module rhp_port_status_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, txn_busy = 1'b0, oc_in = 1'b0, ms_tick = 1'b0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rhp_port_status u_rhp_port_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .txn_busy(txn_busy), .oc_in(oc_in), .ms_tick(ms_tick)
  );

  // {wr, busy, oc, tick, wdata, expected}
  localparam logic [67:0] VEC [12] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h0008_0002}, // R4 rise
    {1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h0008_0002},
    {1'b1, 1'b1, 1'b1, 1'b0, 32'h0008_0000, 32'h0008_0002}, // R8 held
    {1'b0, 1'b1, 1'b1, 1'b0, 32'h0,        32'h0008_0002},
    {1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h0000_0002}, // R8 applied
    {1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        32'h0008_0000}, // R4 fall
    {1'b1, 1'b0, 1'b0, 1'b0, 32'hFFE0_0000, 32'h0008_0000}, // R1 R7 zeros
    {1'b1, 1'b0, 1'b1, 1'b0, 32'h0008_0000, 32'h0008_0002}, // R10
    {1'b1, 1'b0, 1'b1, 1'b0, 32'h0008_0000, 32'h0000_0002}, // R7
    {1'b1, 1'b1, 1'b0, 1'b0, 32'h0008_0000, 32'h0008_0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 32'h0,        32'h0008_0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        32'h0000_0000}  // R8
  };

  task automatic step(input logic w, input logic [31:0] d, input logic b,
                      input logic o, input logic t);
    wr_en = w; wdata = d; txn_busy = b; oc_in = o; ms_tick = t;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; ms_tick = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, rdata, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b0, oc_in, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset value", 32'h0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][67], VEC[i][63:32], VEC[i][66], VEC[i][65], VEC[i][64]);
      check($sformatf("R4/R7/R8/R10 vector %0d", i), VEC[i][31:0]);
    end

    // R1 reserved and unused bits ignore writes
    step(1'b1, 32'hFFE3_FFEA, 1'b0, 1'b0, 1'b0);
    check("R1 reserved ignored", 32'h0);

    // R3 reset timing
    step(1'b1, 32'h10, 1'b0, 1'b0, 1'b0);
    check("R2 R3 reset active", 32'h0000_0010);
    ticks(9);
    check("R3 reset not yet done", 32'h0000_0010);
    ticks(1);
    check("R3 reset done", 32'h0010_0000);

    // R5 resume sequence
    step(1'b1, 32'h1, 1'b0, 1'b0, 1'b0);
    check("R2 suspend", 32'h0010_0001);
    step(1'b1, 32'h4, 1'b0, 1'b0, 1'b0);
    check("R2 resume start", 32'h0010_0005);
    ticks(20);
    check("R5 after drive", 32'h0010_0005);
    for (int i = 0; i < 4; i++) step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    ticks(2);
    check("R5 resync not done", 32'h0010_0005);
    ticks(1);
    check("R5 resume done", 32'h0014_0000);

    // R6 reset completion wipes bit 18
    step(1'b1, 32'h10, 1'b0, 1'b0, 1'b0);
    check("R6 reset start", 32'h0014_0010);
    ticks(10);
    check("R6 bit18 wiped", 32'h0010_0000);

    // R11 reset aborts a resume
    step(1'b1, 32'h0010_0000, 1'b0, 1'b0, 1'b0);
    check("R7 clear bit20", 32'h0);
    step(1'b1, 32'h1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h4, 1'b0, 1'b0, 1'b0);
    ticks(5);
    check("R11 mid resume", 32'h0000_0005);
    step(1'b1, 32'h10, 1'b0, 1'b0, 1'b0);
    check("R11 reset takes over", 32'h0000_0010);
    ticks(10);
    check("R11 reset done", 32'h0010_0000);
    ticks(30);
    check("R11 no resume flag", 32'h0010_0000);

    // R9 merged held clears
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
    check("R4 both flags", 32'h0018_0002);
    step(1'b1, 32'h0010_0000, 1'b1, 1'b1, 1'b0);
    step(1'b1, 32'h0008_0000, 1'b1, 1'b1, 1'b0);
    check("R9 still held", 32'h0018_0002);
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
    check("R9 merged apply", 32'h0000_0002);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule